// File: doc/BRIEF.md
# Predicated Floating-Point Maximum Reduction

This block reduces one wide vector operand to a single floating-point maximum. The element width is chosen per operation by a 2-bit size code: half, single or double precision. A per-byte predicate marks which lanes take part. Lanes that are switched off are replaced by negative infinity of the chosen width before they enter the tree. The surviving lanes are then combined two at a time in a fixed binary tree until one value remains.

Each operation is offered with a one-cycle valid strobe. A new operation can be accepted on every clock. The scalar answer leaves the block zero-extended to 64 bits, together with its own valid strobe. The reserved size code produces no result. It raises an illegal-size flag instead, in the same cycle a result would have appeared.

Top module: `fp_max_reduce`

## Requirements
- R1: For an accepted operation, `result` holds the numerically largest value among the active lanes, so +infinity beats every finite value and -1.0 beats -2.0.
- R2: Size code 2'b01 selects 16-bit lanes, 2'b10 selects 32-bit lanes and 2'b11 selects 64-bit lanes. Lane i occupies `vec_data` bits [i*w +: w], where w is the lane width.
- R3: A lane is active only when `pred_bits` bit (i*w/8) is 1, which is the predicate bit of its lowest byte. The other predicate bits of a lane have no effect. An inactive lane is treated as negative infinity.
- R4: With no active lane, the result is negative infinity of the selected width: 16'hFC00, 32'hFF800000 or 64'hFFF0000000000000.
- R5: If any lane reaching the result is a NaN, the result is that NaN with its top mantissa bit set: bit 9, 22 or 51 for the three widths. When two NaNs meet at a node, the one from the lower-numbered lane is kept.
- R6: Positive zero counts as larger than negative zero.
- R7: `result` bits above the selected width are zero.
- R8: Size code 2'b00 with `in_valid` pulses `bad_size` for one cycle and leaves `out_valid` low; `result` is zero in that cycle.
- R9: `out_valid` pulses exactly ceil(log2(VLEN/16)/2) cycles after the accepting clock edge. Operations on consecutive cycles give results on consecutive cycles.
- R10: During and right after reset, `out_valid` and `bad_size` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| size_code | input | 2 | Lane width select |
| vec_data | input | VLEN | Vector operand |
| pred_bits | input | VLEN/8 | One predicate bit per byte |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Zero-extended maximum |
| bad_size | output | 1 | Reserved size code seen |

## Verification
The bench builds two instances. The first uses VLEN=256, which gives sixteen half-precision lanes, four tree levels and two register stages; every width, the predicate gating, NaN and signed-zero handling and back-to-back streaming are covered there. The second uses VLEN=128, which has three levels. With an odd level count the final register comes after a single level, so this instance checks that the latency still rounds up correctly and that lanes pair correctly in the shorter tree.

// File: rtl/fp_max_reduce.sv
module fp_max_reduce #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        size_code,
  input  logic [VLEN-1:0]   vec_data,
  input  logic [VLEN/8-1:0] pred_bits,
  output logic              out_valid,
  output logic [63:0]       result,
  output logic              bad_size
);
  localparam int L  = VLEN / 16;
  localparam int LV = $clog2(L);

  function automatic logic [63:0] fmx(input logic [63:0] a, input logic [63:0] b,
                                      input logic [1:0] sz);
    logic na, nb;
    logic [63:0] ka, kb, q;
    na = 1'b0; nb = 1'b0; ka = '0; kb = '0; q = '0;
    case (sz)
      2'b01: begin
        na = (&a[14:10]) && (|a[9:0]);
        nb = (&b[14:10]) && (|b[9:0]);
        ka = a[15] ? {48'd0, ~a[15:0]} : {48'd0, 1'b1, a[14:0]};
        kb = b[15] ? {48'd0, ~b[15:0]} : {48'd0, 1'b1, b[14:0]};
        q  = 64'h200;
      end
      2'b10: begin
        na = (&a[30:23]) && (|a[22:0]);
        nb = (&b[30:23]) && (|b[22:0]);
        ka = a[31] ? {32'd0, ~a[31:0]} : {32'd0, 1'b1, a[30:0]};
        kb = b[31] ? {32'd0, ~b[31:0]} : {32'd0, 1'b1, b[30:0]};
        q  = 64'h40_0000;
      end
      2'b11: begin
        na = (&a[62:52]) && (|a[51:0]);
        nb = (&b[62:52]) && (|b[51:0]);
        ka = a[63] ? ~a : {1'b1, a[62:0]};
        kb = b[63] ? ~b : {1'b1, b[62:0]};
        q  = 64'h0008_0000_0000_0000;
      end
      default: return 64'd0;
    endcase
    if (na) return a | q;
    if (nb) return b | q;
    return (kb > ka) ? b : a;
  endfunction

  logic [63:0] leaf [L];
  logic        unused_pred;
  assign unused_pred = ^pred_bits;

  for (genvar j = 0; j < L; j++) begin : g_leaf
    logic [63:0] h, s, d;
    assign h = pred_bits[2*j] ? {48'd0, vec_data[16*j +: 16]} : 64'hFC00;
    if (j < L/2) begin : g_s
      assign s = pred_bits[4*j] ? {32'd0, vec_data[32*j +: 32]} : 64'hFF80_0000;
    end else begin : g_sp
      assign s = 64'hFF80_0000;
    end
    if (j < L/4) begin : g_d
      assign d = pred_bits[8*j] ? vec_data[64*j +: 64] : 64'hFFF0_0000_0000_0000;
    end else begin : g_dp
      assign d = 64'hFFF0_0000_0000_0000;
    end
    always_comb begin
      case (size_code)
        2'b01:   leaf[j] = h;
        2'b10:   leaf[j] = s;
        2'b11:   leaf[j] = d;
        default: leaf[j] = 64'd0;
      endcase
    end
  end

  for (genvar k = 1; k <= LV; k++) begin : g_lvl
    localparam int N = L >> k;
    logic [63:0] src [2*N];
    logic [63:0] c [N];
    logic [63:0] v [N];
    logic [1:0]  src_sz, sz;
    logic        src_vl, src_bd, vl, bd;

    if (k == 1) begin : g_first
      assign src    = leaf;
      assign src_sz = size_code;
      assign src_vl = in_valid && (size_code != 2'b00);
      assign src_bd = in_valid && (size_code == 2'b00);
    end else begin : g_next
      assign src    = g_lvl[k-1].v;
      assign src_sz = g_lvl[k-1].sz;
      assign src_vl = g_lvl[k-1].vl;
      assign src_bd = g_lvl[k-1].bd;
    end

    for (genvar i = 0; i < N; i++) begin : g_node
      assign c[i] = fmx(src[2*i], src[2*i+1], src_sz);
    end

    if ((k % 2 == 0) || (k == LV)) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vl <= 1'b0;
          bd <= 1'b0;
        end else begin
          vl <= src_vl;
          bd <= src_bd;
        end
        sz <= src_sz;
        v  <= c;
      end
    end else begin : g_pass
      assign v  = c;
      assign sz = src_sz;
      assign vl = src_vl;
      assign bd = src_bd;
    end
  end

  assign out_valid = g_lvl[LV].vl;
  assign bad_size  = g_lvl[LV].bd;
  assign result    = (g_lvl[LV].sz == 2'b00) ? 64'd0 : g_lvl[LV].v[0];
endmodule

// File: rtl/fp_max_reduce_chk.sv
module fp_max_reduce_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        size_code,
  input logic [VLEN/8-1:0] pred_bits,
  input logic              out_valid,
  input logic [63:0]       result,
  input logic              bad_size
);
  localparam int LAT = ($clog2(VLEN/16) + 1) / 2;
  logic [3:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 4'hF) age <= age + 4'd1;
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= LAT) |-> (out_valid == $past(in_valid && size_code != 2'b00, LAT)));

  // R8
  bad_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= LAT) |-> (bad_size == $past(in_valid && size_code == 2'b00, LAT)));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && bad_size));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= LAT) && out_valid && $past(size_code, LAT) == 2'b01) |-> (result[63:16] == 48'd0));

  // R4
  empty_ninf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= LAT) && out_valid && $past(size_code, LAT) == 2'b10 && $past(pred_bits == '0, LAT))
      |-> (result == 64'hFF80_0000));
endmodule

bind fp_max_reduce fp_max_reduce_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/fp_max_reduce_test.sv
module fp_max_reduce_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         in_valid = 1'b0;
  logic [1:0]   size_code = 2'b00;
  logic [255:0] vec = '0;
  logic [31:0]  pred = '0;
  logic         out_valid, bad_size;
  logic [63:0]  result;

  logic         s_valid = 1'b0;
  logic [1:0]   s_size = 2'b00;
  logic [127:0] s_vec = '0;
  logic [15:0]  s_pred = '0;
  logic         s_out_valid, s_bad;
  logic [63:0]  s_result;

  int checks = 0;
  int fails = 0;

  fp_max_reduce #(.VLEN(256)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .vec_data(vec), .pred_bits(pred), .out_valid(out_valid), .result(result),
    .bad_size(bad_size));

  fp_max_reduce #(.VLEN(128)) uut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .size_code(s_size),
    .vec_data(s_vec), .pred_bits(s_pred), .out_valid(s_out_valid), .result(s_result),
    .bad_size(s_bad));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clr();
    vec = '0;
    pred = '0;
  endtask

  task automatic put(input int w, input int i, input logic [63:0] val, input bit act);
    for (int b = 0; b < w; b++) vec[i*w + b] = val[b];
    pred[i*w/8] = act;
  endtask

  task automatic fill(input int w, input logic [63:0] val);
    for (int i = 0; i < 256/w; i++) put(w, i, val, 1'b1);
  endtask

  task automatic run(input logic [1:0] sz, input string tag, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1;
    size_code = sz;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " early"}, {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(tag, result, exp);
  endtask

  task automatic t_reset();
    chk("R10 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R10 bad_size in reset", {63'd0, bad_size}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_half_basic();
    clr(); fill(16, 64'h3C00);
    put(16, 7, 64'h4500, 1'b1);
    put(16, 12, 64'h4000, 1'b1);
    run(2'b01, "R1 R2 R7 half max", 64'h4500);
  endtask

  task automatic t_half_neg();
    clr(); fill(16, 64'hC000);
    put(16, 3, 64'hBC00, 1'b1);
    put(16, 9, 64'hC200, 1'b1);
    run(2'b01, "R1 half negatives", 64'hBC00);
  endtask

  task automatic t_inf();
    clr(); fill(16, 64'h3C00);
    put(16, 15, 64'h7C00, 1'b1);
    run(2'b01, "R1 half +inf", 64'h7C00);
  endtask

  task automatic t_pred();
    clr(); fill(16, 64'h3C00);
    put(16, 5, 64'h4700, 1'b0);
    pred[11] = 1'b1;
    run(2'b01, "R3 inactive half lane", 64'h3C00);
  endtask

  task automatic t_single();
    clr(); fill(32, 64'h3F80_0000);
    put(32, 6, 64'h40A0_0000, 1'b1);
    put(32, 2, 64'h42C8_0000, 1'b0);
    pred[9] = 1'b1; pred[10] = 1'b1; pred[11] = 1'b1;
    run(2'b10, "R2 R3 single", 64'h40A0_0000);
  endtask

  task automatic t_double();
    clr(); fill(64, 64'hBFF0_0000_0000_0000);
    put(64, 1, 64'h4014_0000_0000_0000, 1'b1);
    put(64, 3, 64'h4000_0000_0000_0000, 1'b1);
    put(64, 2, 64'h7FF0_0000_0000_0000, 1'b0);
    run(2'b11, "R2 R3 double", 64'h4014_0000_0000_0000);
  endtask

  task automatic t_empty();
    clr(); fill(16, 64'h4500); pred = '0;
    run(2'b01, "R4 empty half", 64'hFC00);
    run(2'b10, "R4 empty single", 64'hFF80_0000);
    run(2'b11, "R4 empty double", 64'hFFF0_0000_0000_0000);
  endtask

  task automatic t_nan();
    clr(); fill(16, 64'h3C00);
    put(16, 4, 64'h7C01, 1'b1);
    run(2'b01, "R5 single NaN quieted", 64'h7E01);
    clr(); fill(16, 64'h3C00);
    put(16, 2, 64'h7C05, 1'b1);
    put(16, 3, 64'h7D00, 1'b1);
    run(2'b01, "R5 lower NaN kept", 64'h7E05);
    clr(); fill(32, 64'h3F80_0000);
    put(32, 5, 64'h7F80_0001, 1'b0);
    run(2'b10, "R3 R5 inactive NaN ignored", 64'h3F80_0000);
  endtask

  task automatic t_zero();
    clr(); fill(16, 64'h8000);
    put(16, 10, 64'h0000, 1'b1);
    run(2'b01, "R6 +0 beats -0", 64'h0000);
    clr(); fill(16, 64'h8000);
    run(2'b01, "R6 all -0", 64'h8000);
  endtask

  task automatic t_bad();
    clr(); fill(16, 64'h4500);
    @(negedge clk);
    in_valid = 1'b1; size_code = 2'b00;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 bad_size pulse", {63'd0, bad_size}, 64'd1);
    chk("R8 no out_valid", {63'd0, out_valid}, 64'd0);
    chk("R8 result zero", result, 64'd0);
    @(negedge clk);
    chk("R8 bad_size clears", {63'd0, bad_size}, 64'd0);
  endtask

  task automatic t_stream();
    clr(); fill(16, 64'h3C00);
    put(16, 0, 64'h4500, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; size_code = 2'b01;
    @(negedge clk);
    clr(); fill(16, 64'h3C00);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 stream first valid", {63'd0, out_valid}, 64'd1);
    chk("R9 stream first", result, 64'h4500);
    @(negedge clk);
    chk("R9 stream second valid", {63'd0, out_valid}, 64'd1);
    chk("R9 stream second", result, 64'h3C00);
    @(negedge clk);
    chk("R9 stream idle", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_small();
    s_vec = '0; s_pred = '0;
    for (int i = 0; i < 8; i++) begin
      s_vec[16*i +: 16] = (i == 7) ? 16'h4500 : 16'h3C00;
      s_pred[2*i] = 1'b1;
    end
    @(negedge clk);
    s_valid = 1'b1; s_size = 2'b01;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R9 narrow early", {63'd0, s_out_valid}, 64'd0);
    @(negedge clk);
    chk("R9 narrow valid", {63'd0, s_out_valid}, 64'd1);
    chk("R1 narrow half", s_result, 64'h4500);
    s_vec = '0; s_pred = '0;
    for (int i = 0; i < 4; i++) begin
      s_vec[32*i +: 32] = (i == 3) ? 32'h40A0_0000 : 32'hC000_0000;
      s_pred[4*i] = (i != 1);
    end
    s_vec[63:32] = 32'h7F80_0000;
    @(negedge clk);
    s_valid = 1'b1; s_size = 2'b10;
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    chk("R3 narrow single", s_result, 64'h40A0_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_half_basic();
    t_half_neg();
    t_inf();
    t_pred();
    t_single();
    t_double();
    t_empty();
    t_nan();
    t_zero();
    t_bad();
    t_stream();
    t_small();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule